// File: doc/BRIEF.md
# Pipelined Late-Write Synchronous Burst SRAM

This block is a synthesizable behavioural model of a synchronous burst SRAM that needs no idle cycle when the data bus changes direction. Every control is sampled on the rising clock edge. The block decodes each enabled edge into one of these cycle types: load-read, load-write, burst continue, deselect, stall or sleep. A small internal array holds the data, split into two 9-bit byte lanes that form an 18-bit word.

Reads are pipelined. The word addressed at an edge is driven on the bus during the following clock period. Writes are late. The data for a write address cycle is taken from the data input, together with the lane enables, at the next enabled edge. Because of this, the bus in any period belongs to the access decoded at the previous edge, and reads and writes can alternate on consecutive cycles. The bus is modelled as a data output plus a drive-enable output. A low drive enable stands for high impedance.

A burst starts at its loaded address. Each continue cycle advances the two low address bits modulo four, and the upper bits stay fixed. Continue cycles use one control encoding for both directions, so the direction always comes from the burst that was loaded.

Top module: `nbt_sram`

## Requirements
- R1: After reset the bus is not driven. A continue cycle issued before any load stays deselected.
- R2: A load-read (adv=0, chip selected, we_n=1) drives the addressed word in the next clock period when oe_n was 0 at the address edge. When oe_n was 1, that period is not driven.
- R3: The chip is selected only when ce1_n=0, ce2=1 and ce3_n=0. Any other load is a deselect: the next period is not driven and no write is scheduled.
- R4: A load-write (adv=0, selected, we_n=0, be_n not 2'b11) stores dq_i at the next enabled edge. be_n[0]=0 enables bits 8:0 and be_n[1]=0 enables bits 17:9. The data period is never driven, whatever oe_n is. A load with we_n=0 and be_n=2'b11 is a deselect.
- R5: On a continue cycle (adv=1) the access direction comes from the loaded burst. we_n has no effect.
- R6: Continue addresses keep the upper address bits of the load and increment the low two bits modulo 4, starting from the loaded low bits.
- R7: A write data cycle with be_n=2'b11 changes no stored bit. The burst address still advances.
- R8: A continue cycle that follows a deselect stays deselected, with the bus not driven and nothing written.
- R9: While cke_n=1 (and sleep=0), edges are ignored. The bus keeps its drive state and data, a pending write stays pending, and the burst position is held.
- R10: While sleep=1 the bus is not driven. A sleep edge drops any pending write and ends the burst, so a following continue is deselected. Stored data is kept.
- R11: A read loaded at the same edge that completes a write to the same address returns the newly written lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | Sleep request, overrides all other controls |
| cke_n | input | 1 | Clock enable, active low |
| adv | input | 1 | 1 = continue burst, 0 = load new address |
| we_n | input | 1 | Write enable for loads, active low |
| be_n | input | 2 | Byte-lane write enables, active low |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable for read cycles, active low |
| addr | input | 6 | Word address |
| dq_i | input | 18 | Write data bus |
| dq_o | output | 18 | Read data bus |
| dq_drv | output | 1 | Bus drive enable; 0 means high impedance |

## Verification
Several properties are checked on every clock by assertions:
- the bus is never driven while a write is pending;
- a write decode always leaves the next period undriven;
- ignored edges freeze the data pipeline;
- sleep clears the pending write;
- the burst counter steps by one on each continue;
- a deselected burst stays deselected across continues.

Other behaviours can only be shown by the bench scenarios against its reference array, because they depend on stored contents:
- lane masking;
- write aborts;
- the wrap order of burst addresses;
- the same-edge write-to-read forwarding;
- data surviving a sleep.

// File: rtl/nbt_sram_pkg.sv
package nbt_sram_pkg;
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;

  typedef enum logic [1:0] {
    BST_IDLE  = 2'd0,
    BST_READ  = 2'd1,
    BST_WRITE = 2'd2
  } burst_e;
endpackage

// File: rtl/nbt_cmd_decode.sv
module nbt_cmd_decode
  import nbt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_i,
  input  logic              cke_n_i,
  input  logic              adv_i,
  input  logic              we_n_i,
  input  logic [LANES-1:0]  be_n_i,
  input  logic              ce1_n_i,
  input  logic              ce2_i,
  input  logic              ce3_n_i,
  input  logic              oe_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              step_en_o,
  output acc_kind_e         acc_kind_o,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic              acc_drive_o
);
  localparam int HI_W = ADDR_W - 2;

  burst_e          bst_q, bst_d;
  logic [HI_W-1:0] base_q, base_d;
  logic [1:0]      cnt_q, cnt_d;
  logic [1:0]      cnt_inc;
  logic            sel;
  logic            any_lane;

  assign sel       = !ce1_n_i && ce2_i && !ce3_n_i;
  assign any_lane  = ~&be_n_i;
  assign step_en_o = !cke_n_i && !sleep_i;
  assign cnt_inc   = cnt_q + 2'd1;

  always_comb begin
    bst_d       = bst_q;
    base_d      = base_q;
    cnt_d       = cnt_q;
    acc_kind_o  = ACC_NONE;
    acc_addr_o  = {base_q, cnt_inc};
    acc_drive_o = 1'b0;
    if (sleep_i) begin
      bst_d = BST_IDLE;
    end else if (step_en_o) begin
      if (!adv_i) begin
        base_d     = addr_i[ADDR_W-1:2];
        cnt_d      = addr_i[1:0];
        acc_addr_o = addr_i;
        if (sel && we_n_i) begin
          acc_kind_o  = ACC_READ;
          acc_drive_o = !oe_n_i;
          bst_d       = BST_READ;
        end else if (sel && any_lane) begin
          acc_kind_o = ACC_WRITE;
          bst_d      = BST_WRITE;
        end else begin
          bst_d = BST_IDLE;
        end
      end else if (bst_q != BST_IDLE) begin
        cnt_d = cnt_inc;
        if (bst_q == BST_READ) begin
          acc_kind_o  = ACC_READ;
          acc_drive_o = !oe_n_i;
        end else begin
          acc_kind_o = ACC_WRITE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bst_q  <= BST_IDLE;
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      bst_q  <= bst_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  // R6: each continue inside a live burst steps the low bits by one
  a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en_o && adv_i && bst_q != BST_IDLE) |=> (cnt_q == 2'($past(cnt_q) + 2'd1)));

  // R8: a continue from the deselected state stays deselected
  a_r8_desel_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en_o && adv_i && bst_q == BST_IDLE) |=> (bst_q == BST_IDLE));

  // R3: a load without full chip select ends in the deselected state
  a_r3_unselected_load: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en_o && !adv_i && !(!ce1_n_i && ce2_i && !ce3_n_i)) |=> (bst_q == BST_IDLE));
endmodule

// File: rtl/nbt_lane_array.sv
module nbt_lane_array #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                     clk,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        wr_addr_i,
  input  logic [LANES-1:0]         wr_lane_en_i,
  input  logic [LANES*LANE_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  output logic [LANES*LANE_W-1:0]  rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic same_addr;
  assign same_addr = wr_en_i && (wr_addr_i == rd_addr_i);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic              lane_wr;

    assign lane_wr = wr_en_i && wr_lane_en_i[l];

    always_ff @(posedge clk) begin
      if (lane_wr) begin
        mem[wr_addr_i] <= wr_data_i[l*LANE_W +: LANE_W];
      end
    end

    // same-edge forwarding keeps a read behind a completing write coherent
    assign rd_data_o[l*LANE_W +: LANE_W] = (same_addr && wr_lane_en_i[l])
                                           ? wr_data_i[l*LANE_W +: LANE_W]
                                           : mem[rd_addr_i];
  end
endmodule

// File: rtl/nbt_data_pipe.sv
module nbt_data_pipe
  import nbt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sleep_i,
  input  logic                     step_en_i,
  input  acc_kind_e                acc_kind_i,
  input  logic [ADDR_W-1:0]        acc_addr_i,
  input  logic                     acc_drive_i,
  input  logic [LANES-1:0]         be_n_i,
  input  logic [LANES*LANE_W-1:0]  rd_word_i,
  output logic                     wr_en_o,
  output logic [ADDR_W-1:0]        wr_addr_o,
  output logic [LANES-1:0]         wr_lane_en_o,
  output logic [LANES*LANE_W-1:0]  dq_o,
  output logic                     dq_drv_o
);
  localparam int WORD_W = LANES * LANE_W;

  logic              drv_q, drv_d;
  logic [WORD_W-1:0] rd_q, rd_d;
  logic              pend_q, pend_d;
  logic [ADDR_W-1:0] pa_q, pa_d;

  always_comb begin
    drv_d  = drv_q;
    rd_d   = rd_q;
    pend_d = pend_q;
    pa_d   = pa_q;
    if (sleep_i) begin
      drv_d  = 1'b0;
      pend_d = 1'b0;
    end else if (step_en_i) begin
      drv_d  = (acc_kind_i == ACC_READ) && acc_drive_i;
      pend_d = (acc_kind_i == ACC_WRITE);
      if (acc_kind_i == ACC_READ)  rd_d = rd_word_i;
      if (acc_kind_i == ACC_WRITE) pa_d = acc_addr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q  <= 1'b0;
      rd_q   <= '0;
      pend_q <= 1'b0;
      pa_q   <= '0;
    end else begin
      drv_q  <= drv_d;
      rd_q   <= rd_d;
      pend_q <= pend_d;
      pa_q   <= pa_d;
    end
  end

  assign wr_en_o      = step_en_i && pend_q;
  assign wr_addr_o    = pa_q;
  assign wr_lane_en_o = ~be_n_i;
  assign dq_o         = rd_q;
  assign dq_drv_o     = drv_q && !sleep_i;

  // R4: the data period of a write is never driven
  a_r4_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en_i && acc_kind_i == ACC_WRITE) |=> (!drv_q && pend_q));

  // R4: bus drive and a pending write never coexist
  a_r4_dir_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_q && pend_q));

  // R9: an ignored edge freezes the data pipeline
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en_i && !sleep_i) |=> ($stable(drv_q) && $stable(rd_q) && $stable(pend_q) && $stable(pa_q)));

  // R10: a sleep edge drops drive and any pending write
  a_r10_sleep_clear: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |=> (!drv_q && !pend_q));
endmodule

// File: rtl/nbt_sram.sv
module nbt_sram
  import nbt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              cke_n,
  input  logic              adv,
  input  logic              we_n,
  input  logic [LANES-1:0]  be_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] dq_i,
  output logic [WORD_W-1:0] dq_o,
  output logic              dq_drv
);
  logic              step_en;
  acc_kind_e         acc_kind;
  logic [ADDR_W-1:0] acc_addr;
  logic              acc_drive;
  logic [WORD_W-1:0] rd_word;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [LANES-1:0]  wr_lane_en;

  nbt_cmd_decode #(.ADDR_W(ADDR_W), .LANES(LANES)) u_dec (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_i     (sleep),
    .cke_n_i     (cke_n),
    .adv_i       (adv),
    .we_n_i      (we_n),
    .be_n_i      (be_n),
    .ce1_n_i     (ce1_n),
    .ce2_i       (ce2),
    .ce3_n_i     (ce3_n),
    .oe_n_i      (oe_n),
    .addr_i      (addr),
    .step_en_o   (step_en),
    .acc_kind_o  (acc_kind),
    .acc_addr_o  (acc_addr),
    .acc_drive_o (acc_drive)
  );

  nbt_lane_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_arr (
    .clk          (clk),
    .wr_en_i      (wr_en),
    .wr_addr_i    (wr_addr),
    .wr_lane_en_i (wr_lane_en),
    .wr_data_i    (dq_i),
    .rd_addr_i    (acc_addr),
    .rd_data_o    (rd_word)
  );

  nbt_data_pipe #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_pipe (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep_i      (sleep),
    .step_en_i    (step_en),
    .acc_kind_i   (acc_kind),
    .acc_addr_i   (acc_addr),
    .acc_drive_i  (acc_drive),
    .be_n_i       (be_n),
    .rd_word_i    (rd_word),
    .wr_en_o      (wr_en),
    .wr_addr_o    (wr_addr),
    .wr_lane_en_o (wr_lane_en),
    .dq_o         (dq_o),
    .dq_drv_o     (dq_drv)
  );
endmodule

// File: tb/nbt_sram_tb_top.sv
module nbt_sram_tb_top;
  localparam int CLK_NS = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sleep, cke_n, adv, we_n, ce1_n, ce2, ce3_n, oe_n;
  logic [1:0]  be_n;
  logic [5:0]  addr;
  logic [17:0] dq_i;
  logic [17:0] dq_o;
  logic        dq_drv;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  nbt_sram dut_i (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .cke_n(cke_n), .adv(adv),
    .we_n(we_n), .be_n(be_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .oe_n(oe_n), .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_drv(dq_drv)
  );

  // reference state
  logic [17:0] ref_mem [64];
  int          st = 0;          // 0 idle, 1 read burst, 2 write burst
  logic [5:0]  bbase = '0;
  logic [1:0]  bcnt = '0;
  bit          pend = 1'b0;
  logic [5:0]  paddr = '0;
  bit          e_drv = 1'b0;
  logic [17:0] e_dat = '0;

  // scoreboard
  bit          q_drv [$];
  logic [17:0] q_dat [$];
  string       q_tag [$];

  function automatic logic [17:0] pat(input int i);
    return 18'((i * 18'h0A5B) ^ 18'h2C3D1);
  endfunction

  task automatic tick(input string tag);
    int kind;
    logic [5:0] a;
    @(posedge clk);
    if (sleep) begin
      e_drv = 1'b0; pend = 1'b0; st = 0;
    end else if (!cke_n) begin
      if (pend) begin
        if (!be_n[0]) ref_mem[paddr][8:0]  = dq_i[8:0];
        if (!be_n[1]) ref_mem[paddr][17:9] = dq_i[17:9];
      end
      kind = 0; a = addr;
      if (!adv) begin
        bbase = addr; bcnt = addr[1:0];
        if (!ce1_n && ce2 && !ce3_n && we_n) kind = 1;
        else if (!ce1_n && ce2 && !ce3_n && be_n != 2'b11) kind = 2;
        st = kind;
      end else if (st != 0) begin
        bcnt = bcnt + 2'd1;
        a = {bbase[5:2], bcnt};
        kind = st;
      end
      e_drv = (kind == 1) && !oe_n;
      if (kind == 1) e_dat = ref_mem[a];
      pend = (kind == 2);
      if (kind == 2) paddr = a;
    end
    q_drv.push_back(e_drv);
    q_dat.push_back(e_dat);
    q_tag.push_back(tag);
    #5;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (q_drv.size() > 0) begin
        bit          d;
        logic [17:0] v;
        string       t;
        bit          ed;
        d = q_drv.pop_front(); v = q_dat.pop_front(); t = q_tag.pop_front();
        ed = d && !sleep;
        n_cmp++;
        if (dq_drv !== ed || (ed && dq_o !== v)) begin
          n_bad++;
          $display("FAIL %s: drv=%0b data=%h expected drv=%0b data=%h", t, dq_drv, dq_o, ed, v);
        end
      end
    end
  end

  task automatic base_in(input logic [1:0] be, input logic [17:0] d);
    sleep = 1'b0; cke_n = 1'b0; be_n = be; dq_i = d;
    ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0; oe_n = 1'b0;
  endtask

  task automatic t_load(input logic [5:0] a, input logic w, input logic oe,
                        input logic c1, input logic c2, input logic c3,
                        input logic [1:0] be, input logic [17:0] d, input string tag);
    base_in(be, d);
    adv = 1'b0; we_n = w; oe_n = oe; addr = a; ce1_n = c1; ce2 = c2; ce3_n = c3;
    tick(tag);
  endtask

  task automatic t_read(input logic [5:0] a, input logic oe, input logic [1:0] be,
                        input logic [17:0] d, input string tag);
    t_load(a, 1'b1, oe, 1'b0, 1'b1, 1'b0, be, d, tag);
  endtask

  task automatic t_write(input logic [5:0] a, input logic [1:0] be,
                         input logic [17:0] d, input string tag);
    t_load(a, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, be, d, tag);
  endtask

  task automatic t_desel(input logic [1:0] be, input logic [17:0] d, input string tag);
    t_load(6'h3F, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, be, d, tag);
  endtask

  task automatic t_cont(input logic w, input logic oe, input logic [1:0] be,
                        input logic [17:0] d, input string tag);
    base_in(be, d);
    adv = 1'b1; we_n = w; oe_n = oe; addr = 6'h15;
    tick(tag);
  endtask

  task automatic t_stall(input logic [17:0] d, input string tag);
    base_in(2'b00, d);
    cke_n = 1'b1; adv = 1'b0; we_n = 1'b0; addr = 6'h2A;
    tick(tag);
  endtask

  task automatic t_sleep(input logic [17:0] d, input string tag);
    base_in(2'b00, d);
    sleep = 1'b1; adv = 1'b0; we_n = 1'b0; addr = 6'h11;
    tick(tag);
  endtask

  initial begin : watchdog
    #(CLK_NS * 100000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : driver
    rst_n = 1'b0;
    base_in(2'b11, '0);
    adv = 1'b1; we_n = 1'b1; addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_cmp++;
    if (dq_drv !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: drv=%0b expected drv=0", dq_drv);
    end
    @(posedge clk); #5;
    rst_n = 1'b1;

    // R1: continue before any load is deselected
    t_cont(1'b1, 1'b0, 2'b11, '0, "R1");
    t_cont(1'b0, 1'b0, 2'b00, 18'h1, "R1");

    // fill words 0..15 back to back (R4, R11 pipelining)
    for (int i = 0; i < 16; i++) t_write(6'(i), 2'b00, (i == 0) ? '0 : pat(i - 1), "R4");
    t_desel(2'b00, pat(15), "R3");

    // R2 reads, oe high gives no drive
    t_read(6'h03, 1'b0, 2'b11, '0, "R2");
    t_read(6'h0F, 1'b0, 2'b11, '0, "R2");
    t_read(6'h03, 1'b1, 2'b11, '0, "R2");
    t_read(6'h0C, 1'b0, 2'b11, '0, "R2");

    // write burst from 0x0A: wraps 0A,0B,08,09 (R6); lane mask, abort
    t_write(6'h0A, 2'b00, '0, "R6");
    t_cont(1'b1, 1'b0, 2'b00, 18'h2AAAA, "R5");
    t_cont(1'b0, 1'b0, 2'b10, 18'h15555, "R4");
    t_cont(1'b0, 1'b0, 2'b11, 18'h3FFFF, "R7");
    t_read(6'h0A, 1'b0, 2'b00, 18'h0BEEF, "R6");
    t_cont(1'b0, 1'b0, 2'b11, '0, "R5");
    t_cont(1'b1, 1'b0, 2'b11, '0, "R7");
    t_cont(1'b1, 1'b0, 2'b11, '0, "R6");
    t_cont(1'b1, 1'b0, 2'b11, '0, "R6");

    // R11 same-edge forwarding
    t_write(6'h20, 2'b00, '0, "R11");
    t_read(6'h20, 1'b0, 2'b00, 18'h1CAFE, "R11");

    // R4 write with oe low stays undriven; be 11 load is a deselect
    t_write(6'h21, 2'b01, '0, "R4");
    t_desel(2'b00, 18'h12345, "R4");
    t_read(6'h21, 1'b0, 2'b11, '0, "R4");
    t_write(6'h05, 2'b11, '0, "R4");
    t_desel(2'b00, 18'h3ABCD, "R4");
    t_read(6'h05, 1'b0, 2'b11, '0, "R4");

    // R3 chip-enable combinations, R8 continue after deselect
    t_load(6'h06, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, '0, "R3");
    t_cont(1'b0, 1'b0, 2'b00, 18'h00777, "R8");
    t_load(6'h06, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'b11, '0, "R3");
    t_cont(1'b1, 1'b0, 2'b11, '0, "R8");
    t_load(6'h07, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'b11, '0, "R3");
    t_read(6'h06, 1'b0, 2'b11, '0, "R3");

    // R9 stall during a read burst, then during a write
    t_read(6'h04, 1'b0, 2'b11, '0, "R9");
    t_stall(18'h3C3C3, "R9");
    t_stall(18'h3C3C3, "R9");
    t_cont(1'b1, 1'b0, 2'b11, '0, "R9");
    t_write(6'h07, 2'b00, '0, "R9");
    t_stall(18'h11111, "R9");
    t_desel(2'b00, 18'h2468A, "R9");
    t_read(6'h07, 1'b0, 2'b11, '0, "R9");

    // R10 sleep
    t_read(6'h08, 1'b0, 2'b11, '0, "R10");
    t_sleep(18'h0, "R10");
    t_cont(1'b1, 1'b0, 2'b11, '0, "R10");
    t_write(6'h09, 2'b00, '0, "R10");
    t_sleep(18'h3EEEE, "R10");
    t_desel(2'b11, '0, "R10");
    t_read(6'h09, 1'b0, 2'b11, '0, "R10");
    t_read(6'h08, 1'b0, 2'b11, '0, "R10");
    t_desel(2'b11, '0, "R1");

    @(negedge clk); #1;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule